// File: doc/BRIEF.md
# Paged effective address generator

This block turns the 16-bit address field of an 8-bit processor's instruction into the final 15-bit address placed on the bus. The top field bit asks for indirection. For arithmetic and logical operands, the next two bits pick an indexing mode and the low 13 bits give an offset inside the current 8 KB page. A 2-bit page register supplies the upper two address bits, and only an absolute branch can load that register. A branch uses all 15 field bits as its target. A port I/O request puts a port-type code on the two upper lines in place of the page.

For an indirect request, the block reads a two-byte pointer through a simple request/acknowledge handshake. It reads the high byte first and then the low byte. The index is added after the pointer is assembled (post-indexing). The index value comes from the register file when a request is accepted. For auto-increment and auto-decrement, the adjusted value is used in the sum and is also sent back to the register file. Choosing which register to use is left to the decoder.

The controller moves through four named states. IDLE accepts a request. A direct request goes from IDLE straight to EMIT. An indirect request goes from IDLE to PTR_HI. PTR_HI goes to PTR_LO when the high byte is acknowledged. PTR_LO goes to EMIT when the low byte is acknowledged. EMIT always returns to IDLE after one cycle.

Top module: `paged_ea_unit`

## Requirements
- R1: After reset, req_ready is 1, ea_valid, rd_req and idx_wr_en are 0, and page_out is 0.
- R2: A direct operand request (req_kind 0, or the reserved code 3, with field bit 15 clear and mode bits 14:13 = 00) gives ea_addr = {page_out, field[12:0]}. ea_valid rises in the cycle after the accepting edge. No index write-back occurs.
- R3: Index-only mode (bits 14:13 = 11) adds the unsigned 8-bit idx_in to the 13-bit offset. The sum wraps modulo 8192 and stays inside the page. No write-back occurs.
- R4: Auto-increment mode (01) uses idx_in+1 (mod 256) as the index. It also drives idx_wr_en with idx_wr_data equal to that value, in the same cycle as ea_valid.
- R5: Auto-decrement mode (10) uses idx_in-1 (mod 256) as the index and writes it back in the same way as R4.
- R6: A direct branch (req_kind 1, bit 15 clear) gives ea_addr = field[14:0]. It loads page_out from field[14:13], and the new page is visible in the ea_valid cycle. page_out changes only in an ea_valid cycle.
- R7: For an indirect request, rd_req holds a steady rd_addr until rd_ack. The high byte is read first, at the pointer address. The low byte is read next, at pointer+1. For operands, pointer+1 wraps inside the 13-bit page offset. For branches, it wraps over 15 bits. Bit 7 of the high byte is ignored.
- R8: An indirect operand gives ea_addr = ({high[6:0], low} + index) mod 2^15, with the index from R3–R5. page_out is left unchanged.
- R9: An indirect branch gives ea_addr equal to the fetched pointer. It loads page_out from pointer bits 14:13. Mode bits and idx_in are ignored, and no write-back occurs.
- R10: A port request (req_kind 2) gives ea_addr = {port_code, 5'b0, field[7:0]} one cycle after acceptance. It never reads memory and leaves page_out unchanged.
- R11: While a request is in progress, req_ready is 0 and req_valid is ignored.
- R12: ea_valid lasts exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 0 operand, 1 branch, 2 port, 3 treated as operand |
| req_field | input | 16 | Instruction address field |
| port_code | input | 2 | Port-type code for port requests |
| idx_in | input | 8 | Index register value from the register file |
| idx_wr_en | output | 1 | Write adjusted index back |
| idx_wr_data | output | 8 | Adjusted index value |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 15 | Pointer byte address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Pointer byte |
| ea_valid | output | 1 | Result strobe |
| ea_addr | output | 15 | Effective address |
| page_out | output | 2 | Current page register |

## Verification
A corrupted page register shows up in the top two bits of the very next operand address. Page changes are checked to happen only in result cycles. A wrong controller state shows up within one cycle as a missing or stretched ea_valid, or as an early or extra rd_req. If the captured index or the pointer high byte is wrong, the error appears in the next ea_addr and idx_wr_data. Pointer-address wrap and high-bit masking are checked at page and address-space ends, so an error in either shows up in rd_addr or ea_addr.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [1:0] {
        K_OPER   = 2'd0,
        K_BRANCH = 2'd1,
        K_PORT   = 2'd2,
        K_RSVD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        IX_NONE = 2'd0,
        IX_INC  = 2'd1,
        IX_DEC  = 2'd2,
        IX_ONLY = 2'd3
    } ixmode_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PTR_HI = 2'd1,
        S_PTR_LO = 2'd2,
        S_EMIT   = 2'd3
    } state_e;
endpackage

// File: rtl/eag_index_unit.sv
module eag_index_unit
    import eag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  ixmode_e           mode,
    input  logic [DATA_W-1:0] idx,
    output logic [DATA_W-1:0] eff,
    output logic              wb
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        eff = '0;
        wb  = 1'b0;
        unique case (mode)
            IX_NONE: begin eff = '0;        wb = 1'b0; end
            IX_INC:  begin eff = idx + ONE; wb = 1'b1; end
            IX_DEC:  begin eff = idx - ONE; wb = 1'b1; end
            IX_ONLY: begin eff = idx;       wb = 1'b0; end
        endcase
    end
endmodule

// File: rtl/eag_page_reg.sv
module eag_page_reg #(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] d,
    output logic [PAGE_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
    import eag_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int PAGE_W = 2,
    parameter int DATA_W = 8,
    parameter int PORT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_kind,
    input  logic [PAGE_W+OFS_W:0]      req_field,
    input  logic [PAGE_W-1:0]          port_code,
    input  logic [DATA_W-1:0]          idx_in,
    output logic                       idx_wr_en,
    output logic [DATA_W-1:0]          idx_wr_data,
    output logic                       rd_req,
    output logic [PAGE_W+OFS_W-1:0]    rd_addr,
    input  logic                       rd_ack,
    input  logic [DATA_W-1:0]          rd_data,
    output logic                       ea_valid,
    output logic [PAGE_W+OFS_W-1:0]    ea_addr,
    output logic [PAGE_W-1:0]          page_out
);
    localparam int ADDR_W  = PAGE_W + OFS_W;
    localparam int FIELD_W = ADDR_W + 1;
    localparam int HI_W    = ADDR_W - DATA_W;
    localparam int PAD_W   = OFS_W - PORT_W;

    state_e state_q, state_d;
    kind_e  kind_in, kind_q;

    logic              f_ind;
    ixmode_e           f_mode, mode_used;
    logic [OFS_W-1:0]  f_ofs;
    logic [DATA_W-1:0] eff_in, eff_q;
    logic              wb_in, wb_q;
    logic              accept, is_branch_in, is_port_in, indirect_in;
    logic [OFS_W-1:0]  ofs_sum;
    logic [ADDR_W-1:0] direct_ea, ptr_start, ptr_q, lo_addr, ind_ea, ea_q;
    logic              wrap_page_q;
    logic [HI_W-1:0]   hi_q;
    logic              page_ld;
    logic [PAGE_W-1:0] page_d, page_q;

    // request field split
    assign f_ind        = req_field[FIELD_W-1];
    assign f_mode       = ixmode_e'(req_field[ADDR_W-1:OFS_W]);
    assign f_ofs        = req_field[OFS_W-1:0];
    assign kind_in      = kind_e'(req_kind);
    assign is_branch_in = (kind_in == K_BRANCH);
    assign is_port_in   = (kind_in == K_PORT);
    assign indirect_in  = f_ind && !is_port_in;
    assign accept       = req_valid && (state_q == S_IDLE);
    assign mode_used    = (is_branch_in || is_port_in) ? IX_NONE : f_mode;

    eag_index_unit #(.DATA_W(DATA_W)) u_index (
        .mode (mode_used),
        .idx  (idx_in),
        .eff  (eff_in),
        .wb   (wb_in)
    );

    // direct address composition
    assign ofs_sum = f_ofs + OFS_W'(eff_in);

    always_comb begin
        unique case (kind_in)
            K_BRANCH: direct_ea = req_field[ADDR_W-1:0];
            K_PORT:   direct_ea = {port_code, {PAD_W{1'b0}}, req_field[PORT_W-1:0]};
            default:  direct_ea = {page_q, ofs_sum};
        endcase
        ptr_start = is_branch_in ? req_field[ADDR_W-1:0] : {page_q, f_ofs};
    end

    // second pointer byte address and indirect result
    assign lo_addr = wrap_page_q
                   ? {ptr_q[ADDR_W-1:OFS_W], ptr_q[OFS_W-1:0] + OFS_W'(1)}
                   : ptr_q + ADDR_W'(1);
    assign ind_ea  = {hi_q, rd_data} + ADDR_W'(eff_q);

    // page register control
    assign page_ld = (accept && is_branch_in && !f_ind)
                   || (state_q == S_PTR_LO && rd_ack && kind_q == K_BRANCH);
    assign page_d  = accept ? req_field[ADDR_W-1:OFS_W] : ind_ea[ADDR_W-1:OFS_W];

    eag_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (page_ld),
        .d     (page_d),
        .q     (page_q)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = indirect_in ? S_PTR_HI : S_EMIT;
            S_PTR_HI: if (rd_ack) state_d = S_PTR_LO;
            S_PTR_LO: if (rd_ack) state_d = S_EMIT;
            S_EMIT:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q      <= K_OPER;
            ptr_q       <= '0;
            wrap_page_q <= 1'b0;
            eff_q       <= '0;
            wb_q        <= 1'b0;
            hi_q        <= '0;
            ea_q        <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept) begin
                    kind_q      <= kind_in;
                    ptr_q       <= ptr_start;
                    wrap_page_q <= !is_branch_in;
                    eff_q       <= eff_in;
                    wb_q        <= wb_in;
                    ea_q        <= direct_ea;
                end
                S_PTR_HI: if (rd_ack) hi_q <= rd_data[HI_W-1:0];
                S_PTR_LO: if (rd_ack) ea_q <= ind_ea;
                S_EMIT:   wb_q <= 1'b0;
            endcase
        end
    end

    assign req_ready   = (state_q == S_IDLE);
    assign rd_req      = (state_q == S_PTR_HI) || (state_q == S_PTR_LO);
    assign rd_addr     = (state_q == S_PTR_HI) ? ptr_q : lo_addr;
    assign ea_valid    = (state_q == S_EMIT);
    assign ea_addr     = ea_q;
    assign idx_wr_en   = (state_q == S_EMIT) && wb_q;
    assign idx_wr_data = eff_q;
    assign page_out    = page_q;
endmodule

// File: rtl/paged_ea_unit_chk.sv
module paged_ea_unit_chk #(
    parameter int OFS_W  = 13,
    parameter int PAGE_W = 2,
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [1:0]              req_kind,
    input logic [PAGE_W+OFS_W:0]   req_field,
    input logic                    idx_wr_en,
    input logic                    rd_req,
    input logic [PAGE_W+OFS_W-1:0] rd_addr,
    input logic                    rd_ack,
    input logic                    ea_valid,
    input logic [PAGE_W-1:0]       page_out
);
    localparam int TOPB = PAGE_W + OFS_W;

    p_direct_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_kind == 2'd2 || !req_field[TOPB])) |=> ea_valid);

    p_wb_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr_en |-> ea_valid);

    p_page_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_out) |-> ea_valid);

    p_fetch_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind != 2'd2 && req_field[TOPB]) |=> (rd_req && !ea_valid));

    p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    p_port_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd2) |=> $stable(page_out));

    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || ea_valid) |-> !req_ready);

    p_one_shot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);
endmodule

bind paged_ea_unit paged_ea_unit_chk #(
    .OFS_W  (OFS_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_field (req_field),
    .idx_wr_en (idx_wr_en),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .ea_valid  (ea_valid),
    .page_out  (page_out)
);

// File: tb/tb_paged_ea_unit.sv
module tb_paged_ea_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_field = '0;
    logic [1:0]  port_code = '0;
    logic [7:0]  idx_in = '0;
    logic        idx_wr_en;
    logic [7:0]  idx_wr_data;
    logic        rd_req;
    logic [14:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        ea_valid;
    logic [14:0] ea_addr;
    logic [1:0]  page_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // results of the last run_req
    logic [14:0] r_ea;
    logic [1:0]  r_page;
    logic        r_wb;
    logic [7:0]  r_wbd;
    logic [14:0] r_hi_a, r_lo_a;
    logic [7:0]  r_hi_d, r_lo_d;
    int          r_reads, r_lat;

    always #(PERIOD/2) clk = ~clk;

    paged_ea_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_field(req_field), .port_code(port_code),
        .idx_in(idx_in), .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .page_out(page_out)
    );

    function automatic logic [7:0] mem_at(input logic [14:0] a);
        logic [7:0] lo5;
        lo5 = a[7:0] * 8'd5;
        return lo5 ^ {a[14:8], 1'b0} ^ 8'h3C;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // issue one request, serve pointer reads, capture result
    task automatic run_req(input logic [1:0] kind, input logic [15:0] field,
                           input logic [1:0] code, input logic [7:0] idx,
                           input int waits, input bit poke);
        int wcnt;
        wcnt = 0;
        r_reads = 0;
        r_lat = 0;
        r_hi_a = '0; r_lo_a = '0; r_hi_d = '0; r_lo_d = '0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_field = field;
        port_code = code; idx_in = idx;
        @(negedge clk);
        req_valid = 1'b0;
        idx_in = 8'hA7;
        for (int i = 0; i < 40; i++) begin
            rd_ack = 1'b0;
            if (ea_valid) begin
                r_ea = ea_addr; r_page = page_out;
                r_wb = idx_wr_en; r_wbd = idx_wr_data;
                req_valid = 1'b0;
                break;
            end
            if (rd_req) begin
                if (poke) begin
                    req_valid = 1'b1; req_kind = 2'd1; req_field = 16'h7123;
                end
                if (wcnt < waits) wcnt++;
                else begin
                    wcnt = 0;
                    rd_ack = 1'b1;
                    if (r_reads == 0) begin
                        r_hi_a = rd_addr; r_hi_d = mem_at(rd_addr) | 8'h80; rd_data = r_hi_d;
                    end else begin
                        r_lo_a = rd_addr; r_lo_d = mem_at(rd_addr); rd_data = r_lo_d;
                    end
                    r_reads++;
                end
            end
            r_lat++;
            @(negedge clk);
        end
        rd_ack = 1'b0;
        check("R12 ea_valid seen", 32'(ea_valid), 32'd1);
        @(negedge clk);
        check("R12 single-cycle ea_valid", 32'(ea_valid), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 ea_valid", 32'(ea_valid), 32'd0);
        check("R1 rd_req", 32'(rd_req), 32'd0);
        check("R1 idx_wr_en", 32'(idx_wr_en), 32'd0);
        check("R1 page_out", 32'(page_out), 32'd0);
    endtask

    task automatic t_direct_operand();
        run_req(2'd0, 16'h0123, 2'd0, 8'h44, 0, 0);
        check("R2 ea page0", 32'(r_ea), 32'h0123);
        check("R2 latency", 32'(r_lat), 32'd0);
        check("R2 no wb", 32'(r_wb), 32'd0);
        check("R2 no reads", 32'(r_reads), 32'd0);
    endtask

    task automatic t_direct_branch();
        run_req(2'd1, 16'h4123, 2'd0, 8'h11, 0, 0);
        check("R6 branch ea", 32'(r_ea), 32'h4123);
        check("R6 page loaded", 32'(r_page), 32'd2);
        check("R6 no wb", 32'(r_wb), 32'd0);
        run_req(2'd3, 16'h0ABC, 2'd0, 8'h99, 0, 0);
        check("R2 reserved kind as operand in page2", 32'(r_ea), 32'h4ABC);
    endtask

    task automatic t_index_modes();
        run_req(2'd0, 16'h7FF0, 2'd0, 8'h20, 0, 0);
        check("R3 index-only wraps in page", 32'(r_ea), 32'h4010);
        check("R3 no wb", 32'(r_wb), 32'd0);
        run_req(2'd0, 16'h2100, 2'd0, 8'hFF, 0, 0);
        check("R4 inc ea", 32'(r_ea), 32'h4100);
        check("R4 wb en", 32'(r_wb), 32'd1);
        check("R4 wb data wraps", 32'(r_wbd), 32'h00);
        run_req(2'd0, 16'h4005, 2'd0, 8'h00, 0, 0);
        check("R5 dec ea", 32'(r_ea), 32'h4104);
        check("R5 wb en", 32'(r_wb), 32'd1);
        check("R5 wb data", 32'(r_wbd), 32'hFF);
    endtask

    task automatic t_indirect_operand();
        logic [14:0] ptr;
        run_req(2'd0, 16'hFFFF, 2'd0, 8'h10, 2, 0);
        check("R7 hi addr", 32'(r_hi_a), 32'h5FFF);
        check("R7 lo addr wraps in page", 32'(r_lo_a), 32'h4000);
        ptr = {r_hi_d[6:0], r_lo_d};
        check("R8 post-index ea", 32'(r_ea), 32'((ptr + 15'h10) & 15'h7FFF));
        check("R8 page unchanged", 32'(r_page), 32'd2);
        run_req(2'd0, 16'hA200, 2'd0, 8'h07, 0, 0);
        check("R7 hi addr inc", 32'(r_hi_a), 32'h4200);
        check("R7 lo addr inc", 32'(r_lo_a), 32'h4201);
        ptr = {r_hi_d[6:0], r_lo_d};
        check("R8 inc post-index ea", 32'(r_ea), 32'(ptr + 15'h8));
        check("R4 indirect wb", 32'(r_wbd), 32'h08);
    endtask

    task automatic t_indirect_branch();
        logic [14:0] ptr;
        run_req(2'd1, 16'hFFFF, 2'd0, 8'h55, 1, 0);
        check("R7 branch hi addr", 32'(r_hi_a), 32'h7FFF);
        check("R7 branch lo addr wraps 15b", 32'(r_lo_a), 32'h0000);
        ptr = {r_hi_d[6:0], r_lo_d};
        check("R9 branch ea ignores index", 32'(r_ea), 32'(ptr));
        check("R9 page from pointer", 32'(r_page), 32'(ptr[14:13]));
        check("R9 no wb", 32'(r_wb), 32'd0);
    endtask

    task automatic t_port();
        logic [1:0] pg;
        pg = page_out;
        run_req(2'd2, 16'h80C3, 2'd3, 8'h12, 0, 0);
        check("R10 port ea", 32'(r_ea), 32'h60C3);
        check("R10 no reads", 32'(r_reads), 32'd0);
        check("R10 page kept", 32'(r_page), 32'(pg));
    endtask

    task automatic t_busy_ignored();
        logic [14:0] ptr;
        run_req(2'd1, 16'h8000 | 16'h2ABC, 2'd0, 8'h00, 3, 1);
        ptr = {r_hi_d[6:0], r_lo_d};
        check("R11 first result kept", 32'(r_ea), 32'(ptr));
        check("R11 page from first only", 32'(r_page), 32'(ptr[14:13]));
        check("R11 no second result", 32'(ea_valid), 32'd0);
        check("R11 page after", 32'(page_out), 32'(ptr[14:13]));
        check("R11 ready again", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_operand();
        t_direct_branch();
        t_index_modes();
        t_indirect_operand();
        t_indirect_branch();
        t_port();
        t_busy_ignored();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule